// File: doc/BRIEF.md
# Process-Qualified Performance Event Counter

This block is a set of event counters that feeds a performance-monitoring interrupt. Each counter takes a one-cycle event pulse from outside. It advances only while the processor's present state matches a mode that software has programmed. That state is made of two bits: whether the processor runs privileged (supervisor) or unprivileged (user) code, and whether the running process carries a software-set mark. A control register holds five bits that choose which states are counted. A sixth bit enables the interrupt.

A counter is treated as overflowed once its most-significant bit is set. When the interrupt is enabled and any counter shows that bit, the block raises a level interrupt request that stays up until software clears the bit. On the first cycle of that request the block records an instruction address. If a threshold event is flagged in that cycle, it records the address of the triggering instruction. Otherwise it records the address of the last instruction that completed. Supervisor code can read and write the recorded address. A read-only copy is open to user code.

Software reaches everything through a small register port. The port has a 3-bit address, a write strobe and a privilege flag, and it returns read data one cycle after the address is presented.

Top module: `pmon_unit`

## Requirements
- R1: When control bits 4..0 are all zero, every event pulse advances its counter whatever the privilege and mark inputs are.
- R2: When control bit 0 (disable) is 1, no counter advances, whatever the other control bits and the state inputs are.
- R3: Control bit 1 restricts counting to supervisor state (in_super=1), and control bit 2 restricts it to user state (in_super=0). Setting both bits counts nothing.
- R4: Control bit 3 restricts counting to a marked process (in_marked=1), and control bit 4 restricts it to an unmarked process. Setting both counts nothing. Each of these bits combines with R3 as a logical AND.
- R5: Counters are independent. Counter i advances by one on the clock edge after which evt_pulse[i] was high while counting was enabled, and it wraps from 0xFFFFFFFF to 0.
- R6: A register write to a counter takes effect in place of an increment that falls in the same cycle.
- R7: irq goes high one cycle after control bit 5 (interrupt enable) is 1 and any counter's bit 31 is 1. It stays high while both conditions hold and falls one cycle after either one clears.
- R8: On the cycle in which irq rises, if thr_hit is 1, the sampled-address register takes thr_iaddr.
- R9: On the cycle in which irq rises, if thr_hit is 0, the sampled-address register takes done_iaddr. While irq stays high the register is not recaptured.
- R10: The address map is 0 for control, 1 for the sampled address, 2 for the user copy, and 4+i for counter i. reg_rdata shows the register addressed in the cycle before. A write to address 1 lands only when reg_super=1. A read of address 1 with reg_super=0 returns 0.
- R11: Address 2 always reads the sampled-address value at any privilege, and a write to address 2 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NCNT | One event pulse per counter |
| in_super | input | 1 | Processor in supervisor state |
| in_marked | input | 1 | Running process is marked |
| thr_hit | input | 1 | Threshold event flagged this cycle |
| thr_iaddr | input | DW | Address of the threshold instruction |
| done_iaddr | input | DW | Address of the last completed instruction |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_super | input | 1 | Access made at supervisor level |
| reg_rdata | output | DW | Registered read data |
| irq | output | 1 | Performance-monitor interrupt request |

## Verification
A wrong mode decode shows up as a counter value that differs from the number of pulses issued. This becomes visible on the first readback after a single pulse in the state being tested. A missed or stale overflow flag shows on irq one cycle after the counter's top bit changes. A wrong capture choice or a recapture shows as a wrong value at address 1 or address 2 on the next read. These tests deliberately change the thr_iaddr and done_iaddr inputs while irq stays high, so that a recapture cannot go unnoticed.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int CTRL_W = 6;
  // control field positions
  localparam int C_DIS    = 0;
  localparam int C_SUPV   = 1;
  localparam int C_USER   = 2;
  localparam int C_MARK   = 3;
  localparam int C_UNMARK = 4;
  localparam int C_IE     = 5;
  // register map
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_SAMP  = 3'd1;
  localparam logic [2:0] A_USAMP = 3'd2;
  localparam logic [2:0] A_CNT0  = 3'd4;
endpackage

// File: rtl/pmon_mode_gate.sv
module pmon_mode_gate
  import pmon_pkg::*;
(
  input  logic [4:0] mode,
  input  logic       in_super,
  input  logic       in_marked,
  output logic       cnt_en
);
  logic priv_ok, mark_ok;

  always_comb begin
    priv_ok = (!mode[C_SUPV] || in_super) && (!mode[C_USER] || !in_super);
    mark_ok = (!mode[C_MARK] || in_marked) && (!mode[C_UNMARK] || !in_marked);
    cnt_en  = !mode[C_DIS] && priv_ok && mark_ok;
  end
endmodule

// File: rtl/pmon_counter_bank.sv
module pmon_counter_bank #(
  parameter int NCNT = 4,
  parameter int DW   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [NCNT-1:0]  evt,
  input  logic [NCNT-1:0]  wr_sel,
  input  logic [DW-1:0]    wdata,
  output logic [NCNT*DW-1:0] cnt_flat,
  output logic [NCNT-1:0]  msb
);
  logic [DW-1:0] cnt_q [NCNT];

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                cnt_q[i] <= '0;
      else if (wr_sel[i])     cnt_q[i] <= wdata;
      else if (cnt_en && evt[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
    end
    assign cnt_flat[i*DW +: DW] = cnt_q[i];
    assign msb[i] = cnt_q[i][DW-1];

    // R5: untouched counter holds its value
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (!wr_sel[i] && !(cnt_en && evt[i])) |=> $stable(cnt_q[i]));
    // R5: enabled pulse steps by exactly one
    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
      (!wr_sel[i] && cnt_en && evt[i]) |=> cnt_q[i] == $past(cnt_q[i]) + 1'b1);
    // R6: write beats increment
    a_r6_write_wins: assert property (@(posedge clk) disable iff (rst)
      wr_sel[i] |=> cnt_q[i] == $past(wdata));
  end
endmodule

// File: rtl/pmon_sample_capture.sv
module pmon_sample_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_cond,
  input  logic          thr_hit,
  input  logic [DW-1:0] thr_iaddr,
  input  logic [DW-1:0] done_iaddr,
  input  logic          sw_we,
  input  logic [DW-1:0] sw_wdata,
  output logic          irq_q,
  output logic [DW-1:0] samp_q
);
  logic rise;
  assign rise = irq_cond && !irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      samp_q <= '0;
    end else begin
      irq_q <= irq_cond;
      if (rise)       samp_q <= thr_hit ? thr_iaddr : done_iaddr;
      else if (sw_we) samp_q <= sw_wdata;
    end
  end

  // R8: threshold-triggered capture takes the exact instruction address
  a_r8_thr_capture: assert property (@(posedge clk) disable iff (rst)
    (irq_cond && !irq_q && thr_hit) |=> samp_q == $past(thr_iaddr));
  // R9: otherwise last completed address
  a_r9_done_capture: assert property (@(posedge clk) disable iff (rst)
    (irq_cond && !irq_q && !thr_hit) |=> samp_q == $past(done_iaddr));
  // R9: no recapture while request held
  a_r9_no_recapture: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !sw_we) |=> $stable(samp_q));
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
  import pmon_pkg::*;
#(
  parameter int NCNT = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCNT-1:0] evt_pulse,
  input  logic            in_super,
  input  logic            in_marked,
  input  logic            thr_hit,
  input  logic [DW-1:0]   thr_iaddr,
  input  logic [DW-1:0]   done_iaddr,
  input  logic [2:0]      reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_super,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);
  localparam int SEL_W = (NCNT > 1) ? $clog2(NCNT) : 1;

  logic [CTRL_W-1:0]  ctrl_q;
  logic               cnt_en;
  logic [NCNT-1:0]    wr_sel;
  logic [NCNT*DW-1:0] cnt_flat;
  logic [NCNT-1:0]    msb;
  logic               irq_cond;
  logic [DW-1:0]      samp;
  logic               samp_we;
  logic [SEL_W-1:0]   cidx;

  assign cidx = reg_addr[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (reg_we && reg_addr == A_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_wsel
    assign wr_sel[i] = reg_we && reg_addr[2] && (cidx == SEL_W'(i));
  end

  assign samp_we  = reg_we && reg_super && (reg_addr == A_SAMP);
  assign irq_cond = ctrl_q[C_IE] && (|msb);

  pmon_mode_gate u_gate (
    .mode      (ctrl_q[4:0]),
    .in_super  (in_super),
    .in_marked (in_marked),
    .cnt_en    (cnt_en)
  );

  pmon_counter_bank #(.NCNT(NCNT), .DW(DW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .evt      (evt_pulse),
    .wr_sel   (wr_sel),
    .wdata    (reg_wdata),
    .cnt_flat (cnt_flat),
    .msb      (msb)
  );

  pmon_sample_capture #(.DW(DW)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .irq_cond   (irq_cond),
    .thr_hit    (thr_hit),
    .thr_iaddr  (thr_iaddr),
    .done_iaddr (done_iaddr),
    .sw_we      (samp_we),
    .sw_wdata   (reg_wdata),
    .irq_q      (irq),
    .samp_q     (samp)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      if (reg_addr[2]) begin
        for (int i = 0; i < NCNT; i++)
          if (cidx == SEL_W'(i)) reg_rdata <= cnt_flat[i*DW +: DW];
      end else begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= DW'(ctrl_q);
          A_SAMP:  reg_rdata <= reg_super ? samp : '0;
          A_USAMP: reg_rdata <= samp;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  // R7: request follows enable and top bits
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_IE] && (|msb)) |=> irq);
  a_r7_irq_off: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[C_IE] |=> !irq);
  // R2: disable freezes counters unless written
  a_r2_disabled_frozen: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_DIS] && !reg_we) |=> $stable(cnt_flat));
  // R11: user copy mirrors sampled register
  a_r11_mirror: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_USAMP) |=> reg_rdata == $past(samp));
  // R10: user-level read of sampled register is blanked
  a_r10_user_blank: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_SAMP && !reg_super) |=> reg_rdata == '0);
endmodule

// File: tb/pmon_unit_bench.sv
module pmon_unit_bench;
  localparam int NCNT = 4;
  localparam int DW   = 32;

  logic clk = 0;
  logic rst;
  logic [NCNT-1:0] evt_pulse;
  logic in_super, in_marked, thr_hit;
  logic [DW-1:0] thr_iaddr, done_iaddr;
  logic [2:0] reg_addr;
  logic reg_we, reg_super;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pmon_unit #(.NCNT(NCNT), .DW(DW)) u_pmon_unit (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .in_super(in_super),
    .in_marked(in_marked), .thr_hit(thr_hit), .thr_iaddr(thr_iaddr),
    .done_iaddr(done_iaddr), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_super(reg_super), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input logic sup);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1; reg_super = sup;
    @(negedge clk);
    reg_we = 0; reg_super = 1;
  endtask

  task automatic rd(input logic [2:0] a, input logic sup, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_super = sup;
    @(negedge clk);
    d = reg_rdata;
    reg_super = 1;
  endtask

  task automatic pulse(input logic [NCNT-1:0] m, input logic sup, input logic mk);
    @(negedge clk);
    evt_pulse = m; in_super = sup; in_marked = mk;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic clear_cnt();
    for (int i = 0; i < NCNT; i++) wr(3'(4 + i), '0, 1);
  endtask

  // one pulse in each of the four states on counter 0; returns count
  task automatic sweep(input logic [5:0] c, output logic [DW-1:0] v);
    wr(3'd0, DW'(c), 1);
    wr(3'd4, '0, 1);
    pulse(4'b0001, 1, 1);
    pulse(4'b0001, 1, 0);
    pulse(4'b0001, 0, 1);
    pulse(4'b0001, 0, 0);
    rd(3'd4, 1, v);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R7 reset irq", DW'(irq), 0);
    rd(3'd5, 1, v); check("R5 reset counter", v, 0);
    rd(3'd0, 1, v); check("R10 reset ctrl", v, 0);
  endtask

  task automatic t_uncond();
    logic [DW-1:0] v;
    sweep(6'h00, v); check("R1 unconditional", v, 4);
    pulse(4'b1010, 0, 1);
    pulse(4'b1000, 1, 0);
    rd(3'd5, 1, v); check("R5 independent ctr1", v, 1);
    rd(3'd7, 1, v); check("R5 independent ctr3", v, 2);
    rd(3'd6, 1, v); check("R5 independent ctr2", v, 0);
  endtask

  task automatic t_disable();
    logic [DW-1:0] v;
    sweep(6'h01, v); check("R2 disable", v, 0);
    sweep(6'h1F, v); check("R2 disable with all bits", v, 0);
  endtask

  task automatic t_priv();
    logic [DW-1:0] v;
    sweep(6'h02, v); check("R3 supervisor only", v, 2);
    sweep(6'h04, v); check("R3 user only", v, 2);
    sweep(6'h06, v); check("R3 both conflict", v, 0);
  endtask

  task automatic t_mark();
    logic [DW-1:0] v;
    sweep(6'h08, v); check("R4 marked only", v, 2);
    sweep(6'h10, v); check("R4 unmarked only", v, 2);
    sweep(6'h18, v); check("R4 both conflict", v, 0);
    // marked and user: only (sup=0,mk=1)
    sweep(6'h0C, v); check("R4 marked and user", v, 1);
    // unmarked and supervisor: only (sup=1,mk=0)
    sweep(6'h12, v); check("R4 unmarked and supervisor", v, 1);
  endtask

  task automatic t_write_prio();
    logic [DW-1:0] v;
    wr(3'd0, 0, 1);
    @(negedge clk);
    evt_pulse = 4'b0100; reg_addr = 3'd6; reg_wdata = 32'h55; reg_we = 1;
    @(negedge clk);
    evt_pulse = '0; reg_we = 0;
    rd(3'd6, 1, v); check("R6 write beats increment", v, 32'h55);
    wr(3'd6, 32'hFFFF_FFFF, 1);
    pulse(4'b0100, 0, 0);
    rd(3'd6, 1, v); check("R5 wrap to zero", v, 0);
  endtask

  task automatic t_irq();
    logic [DW-1:0] v;
    clear_cnt();
    wr(3'd0, 32'h20, 1);
    check("R7 no irq before overflow", DW'(irq), 0);
    wr(3'd5, 32'h7FFF_FFFF, 1);
    @(negedge clk);
    thr_hit = 1; thr_iaddr = 32'hA000_0010; done_iaddr = 32'hB000_0020;
    evt_pulse = 4'b0010;
    @(negedge clk);           // counter now 0x80000000
    evt_pulse = '0;
    check("R7 irq not yet", DW'(irq), 0);
    @(negedge clk);           // irq raised, capture done
    thr_hit = 0;
    check("R7 irq raised", DW'(irq), 1);
    rd(3'd1, 1, v); check("R8 threshold address", v, 32'hA000_0010);
    rd(3'd2, 0, v); check("R11 user copy", v, 32'hA000_0010);
    // held: change inputs, no recapture
    thr_iaddr = 32'h1111_1111; done_iaddr = 32'h2222_2222; thr_hit = 1;
    repeat (3) @(negedge clk);
    thr_hit = 0;
    rd(3'd1, 1, v); check("R9 no recapture while held", v, 32'hA000_0010);
    check("R7 irq held", DW'(irq), 1);
    // clear top bit
    wr(3'd5, 0, 1);
    @(negedge clk);
    check("R7 irq falls after clear", DW'(irq), 0);
    // second trigger without threshold
    done_iaddr = 32'hC0DE_0004;
    wr(3'd7, 32'h8000_0000, 1);
    @(negedge clk);
    done_iaddr = 32'h0;
    check("R7 irq from written top bit", DW'(irq), 1);
    rd(3'd1, 1, v); check("R9 last completed address", v, 32'hC0DE_0004);
    // disable interrupt
    wr(3'd0, 0, 1);
    @(negedge clk);
    check("R7 irq off when disabled", DW'(irq), 0);
  endtask

  task automatic t_access();
    logic [DW-1:0] v;
    rd(3'd1, 0, v); check("R10 user read blanked", v, 0);
    wr(3'd1, 32'hDEAD_BEEF, 0);
    rd(3'd1, 1, v); check("R10 user write ignored", v, 32'hC0DE_0004);
    wr(3'd2, 32'h1234_5678, 1);
    rd(3'd2, 1, v); check("R11 copy write ignored", v, 32'hC0DE_0004);
    wr(3'd1, 32'h0BAD_F00D, 1);
    rd(3'd1, 1, v); check("R10 supervisor write", v, 32'h0BAD_F00D);
    rd(3'd2, 0, v); check("R11 copy follows write", v, 32'h0BAD_F00D);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; evt_pulse = '0; in_super = 0; in_marked = 0; thr_hit = 0;
    thr_iaddr = '0; done_iaddr = '0; reg_addr = '0; reg_we = 0;
    reg_wdata = '0; reg_super = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_uncond();
    t_disable();
    t_priv();
    t_mark();
    t_write_prio();
    t_irq();
    t_access();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule